// File: doc/BRIEF.md
# Bridge Gate Driver with Digital Dead Time

This block converts one pulse-width-modulated bit per audio channel into the gate signals for a bridge-tied loudspeaker load. Each channel drives two half-bridges. Each half-bridge is a complementary pair of an N-channel and a P-channel MOSFET. The first half-bridge follows the PWM bit and the second follows its inverse, so each channel has four gate outputs.

A two-bit mode input selects how the gates switch. In one mode every gate changes together on the rising master-clock edge, and any dead time is left to the external gate buffers. In the other mode the drive is break-before-make with a digital dead time of half a clock period: the conducting transistor is released on the rising edge and the opposite one is enabled on the following falling edge.

An active-low mute input parks every transistor in the off state. Each channel is controlled by a four-state machine:

- `CH_BOOT` is the state after reset.
- `CH_HIGH` means the PWM bit is 1.
- `CH_LOW` means the PWM bit is 0.
- `CH_MUTE` is the parked state.

The transitions are:

- BOOT to HIGH, LOW or MUTE on the first rising edge after reset.
- HIGH to LOW and LOW to HIGH when the sampled PWM bit changes.
- HIGH or LOW to MUTE when mute is sampled low.
- MUTE to HIGH or LOW on the first PWM change seen while mute is released.

Top module: `hbridge_gate_drv`

## Requirements
- R1: Channel c owns half-bridges 2c (side A) and 2c+1 (side B). While the channel is driving, side A is at the high level when the PWM bit is 1 and side B is at the opposite level, so the two sides are always in antiphase.
- R2: The N gate is active high (1 = on) and the P gate is active low (0 = on). The three half-bridge levels are encoded as follows: off is P=1, N=0; high is P=0, N=0; low is P=1, N=1.
- R3: With mode = 2'b00, every gate of a half-bridge changes on the rising clock edge that samples the new PWM or mute value.
- R4: With mode = 2'b01, a transistor that turns off does so on the rising edge that samples the change, and the transistor that turns on does so on the next falling edge. The gap is half a clock period.
- R5: The mode codes 2'b10 and 2'b11 behave exactly like the dead-time mode.
- R6: The N and P transistors of one half-bridge are never on at the same time.
- R7: When mute_n is sampled 0 on a rising edge, all N gates are 0 and all P gates are 1 from that edge onward for as long as mute_n stays 0.
- R8: After mute_n returns to 1, a channel stays off until a rising edge samples a PWM bit that differs from the one sampled on the previous rising edge. Each channel resumes independently of the others.
- R9: Reset (rst_n = 0) turns every gate off at once. All gates stay off until the first rising edge after reset is released has sampled the PWM inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; both of its edges are used |
| rst_n | input | 1 | Asynchronous active-low reset |
| mute_n | input | 1 | Active-low mute |
| mode | input | 2 | Switching mode; bit 0 and bit 1 are the two mode pins |
| pwm | input | NUM_CH | One PWM bit per channel (bit 0 = left) |
| gate_n | output | 2*NUM_CH | N-channel gate drive, active high, index 2c+side |
| gate_p | output | 2*NUM_CH | P-channel gate drive, active low, index 2c+side |

## Verification
The hardest condition to reach from the ports is a channel that has been muted and then unmuted with its PWM bit unchanged. That channel must stay off while its neighbour channel resumes. The stimulus table therefore mutes both channels and releases mute with the PWM bits held. It then toggles only one channel's bit, so one channel resumes and the other stays parked. A directed sequence also enters mute straight from reset. The intermediate dead-time state exists only between a rising and a falling edge, so every vector is sampled twice: once in that half period and once after the falling edge.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

    typedef enum logic [1:0] {
        CH_BOOT = 2'd0,
        CH_HIGH = 2'd1,
        CH_LOW  = 2'd2,
        CH_MUTE = 2'd3
    } ch_state_e;

    typedef enum logic [1:0] {
        HB_OFF = 2'd0,
        HB_HI  = 2'd1,
        HB_LO  = 2'd2
    } hb_lvl_e;

endpackage

// File: rtl/hbg_chan_fsm.sv
module hbg_chan_fsm
    import hbg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    mute_n,
    input  logic    pwm,
    output hb_lvl_e lvl_a,
    output hb_lvl_e lvl_b
);

    ch_state_e state_q;
    ch_state_e state_d;
    logic      pwm_last;

    // State register and the PWM bit taken on the previous rising edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CH_BOOT;
            pwm_last <= 1'b0;
        end else begin
            state_q  <= state_d;
            pwm_last <= pwm;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_BOOT: begin
                if (!mute_n)  state_d = CH_MUTE;
                else if (pwm) state_d = CH_HIGH;
                else          state_d = CH_LOW;
            end
            CH_HIGH: begin
                if (!mute_n)   state_d = CH_MUTE;
                else if (!pwm) state_d = CH_LOW;
            end
            CH_LOW: begin
                if (!mute_n)  state_d = CH_MUTE;
                else if (pwm) state_d = CH_HIGH;
            end
            CH_MUTE: begin
                if (mute_n && (pwm != pwm_last))
                    state_d = pwm ? CH_HIGH : CH_LOW;
            end
            default: state_d = CH_BOOT;
        endcase
    end

    // Output decode: the two sides of the bridge are in antiphase
    always_comb begin
        unique case (state_q)
            CH_HIGH: begin
                lvl_a = HB_HI;
                lvl_b = HB_LO;
            end
            CH_LOW: begin
                lvl_a = HB_LO;
                lvl_b = HB_HI;
            end
            default: begin
                lvl_a = HB_OFF;
                lvl_b = HB_OFF;
            end
        endcase
    end

endmodule

// File: rtl/hbg_deadtime.sv
module hbg_deadtime
    import hbg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    dt_en,
    input  hb_lvl_e lvl,
    output logic    gate_n,
    output logic    gate_p
);

    hb_lvl_e lvl_fall;

    // Copy of the target level taken on the falling edge
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) lvl_fall <= HB_OFF;
        else        lvl_fall <= lvl;
    end

    logic n_on;
    logic p_on;

    // Turn-off follows the rising-edge level at once. In dead-time mode,
    // turn-on also waits until the falling-edge copy agrees.
    always_comb begin
        n_on = (lvl == HB_LO) && (!dt_en || (lvl_fall == HB_LO));
        p_on = (lvl == HB_HI) && (!dt_en || (lvl_fall == HB_HI));
    end

    assign gate_n = n_on;
    assign gate_p = ~p_on;

endmodule

// File: rtl/hbridge_gate_drv.sv
module hbridge_gate_drv
    import hbg_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mute_n,
    input  logic [1:0]            mode,
    input  logic [NUM_CH-1:0]     pwm,
    output logic [2*NUM_CH-1:0]   gate_n,
    output logic [2*NUM_CH-1:0]   gate_p
);

    localparam int NUM_HB = 2 * NUM_CH;

    // Only code 00 switches without dead time; the other codes add it
    logic dt_en;
    assign dt_en = |mode;

    hb_lvl_e lvl [NUM_HB];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        hbg_chan_fsm u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .mute_n (mute_n),
            .pwm    (pwm[c]),
            .lvl_a  (lvl[2*c]),
            .lvl_b  (lvl[2*c+1])
        );
    end

    for (genvar h = 0; h < NUM_HB; h++) begin : g_hb
        hbg_deadtime u_dt (
            .clk    (clk),
            .rst_n  (rst_n),
            .dt_en  (dt_en),
            .lvl    (lvl[h]),
            .gate_n (gate_n[h]),
            .gate_p (gate_p[h])
        );
    end

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
    parameter int NUM_CH = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mute_n,
    input logic [1:0]          mode,
    input logic [NUM_CH-1:0]   pwm,
    input logic [2*NUM_CH-1:0] gate_n,
    input logic [2*NUM_CH-1:0] gate_p
);

    localparam int NUM_HB = 2 * NUM_CH;

    logic              seen;
    logic [NUM_HB-1:0] set_n;
    logic [NUM_HB-1:0] set_p;

    // Gate values settled before each rising edge, plus a flag that a sample has been taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            set_n <= '0;
            set_p <= '1;
        end else begin
            seen  <= 1'b1;
            set_n <= gate_n;
            set_p <= gate_p;
        end
    end

    for (genvar h = 0; h < NUM_HB; h++) begin : g_hb
        a_r6_no_shoot_rise: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_n[h] && !gate_p[h]));
        a_r6_no_shoot_fall: assert property (@(negedge clk) disable iff (!rst_n)
            !(gate_n[h] && !gate_p[h]));
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        a_r1_antiphase: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_n[2*c+1] == !gate_p[2*c]) && (gate_n[2*c] == !gate_p[2*c+1]));
    end

    a_r7_mute_off: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_n |=> (gate_n == '0 && gate_p == '1));

    a_r9_boot_off: assert property (@(posedge clk) disable iff (!rst_n)
        !seen |-> (gate_n == '0 && gate_p == '1));

    // R4 and R5: in dead-time modes no gate turns on between a rising and the next falling edge
    a_r4_no_turn_on_at_rise: assert property (@(negedge clk) disable iff (!rst_n)
        (mode != 2'b00) |-> (((gate_n & ~set_n) == '0) && ((~gate_p & set_p) == '0)));

endmodule

bind hbridge_gate_drv hbg_checker #(.NUM_CH(NUM_CH)) u_hbg_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .mute_n (mute_n),
    .mode   (mode),
    .pwm    (pwm),
    .gate_n (gate_n),
    .gate_p (gate_p)
);

// File: tb/test_hbridge_gate_drv.sv
module test_hbridge_gate_drv;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mute_n = 1'b1;
    logic [1:0] mode = 2'b01;
    logic [1:0] pwm = 2'b00;
    logic [3:0] gate_n;
    logic [3:0] gate_p;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    hbridge_gate_drv #(.NUM_CH(2)) i_hbridge_gate_drv (
        .clk    (clk),
        .rst_n  (rst_n),
        .mute_n (mute_n),
        .mode   (mode),
        .pwm    (pwm),
        .gate_n (gate_n),
        .gate_p (gate_p)
    );

    // Vector fields: {mode[1:0], mute_n, pwm[1:0], ch1 code, ch0 code}
    // Channel codes: 0 = off, 1 = high (PWM bit 1), 2 = low (PWM bit 0)
    localparam logic [8:0] VEC [12] = '{
        9'b01_1_00_10_10,
        9'b01_1_01_10_01,
        9'b01_1_10_01_10,
        9'b00_1_01_10_01,
        9'b00_1_10_01_10,
        9'b00_0_10_00_00,
        9'b00_1_10_00_00,
        9'b01_1_11_00_01,
        9'b11_1_00_10_10,
        9'b10_1_01_10_01,
        9'b01_1_01_10_01,
        9'b01_0_01_00_00
    };

    // Half-bridge levels packed 2 bits each: 0 off, 1 high, 2 low
    function automatic logic [7:0] ch2lv(input logic [3:0] cc);
        logic [7:0] lv = '0;
        for (int c = 0; c < 2; c++) begin
            case (cc[2*c +: 2])
                2'd1:    lv[4*c +: 4] = {2'd2, 2'd1};
                2'd2:    lv[4*c +: 4] = {2'd1, 2'd2};
                default: lv[4*c +: 4] = 4'd0;
            endcase
        end
        return lv;
    endfunction

    // Gate encoding from R2, returned as {gate_p, gate_n}
    function automatic logic [7:0] enc(input logic [7:0] lv);
        logic [3:0] p = '1;
        logic [3:0] n = '0;
        for (int k = 0; k < 4; k++) begin
            if (lv[2*k +: 2] == 2'd1) p[k] = 1'b0;
            if (lv[2*k +: 2] == 2'd2) n[k] = 1'b1;
        end
        return {p, n};
    endfunction

    task automatic chk(input string tag, input logic [7:0] exp);
        logic [7:0] act = {gate_p, gate_n};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
        checks++;
        if ((gate_n & ~gate_p) != 4'b0000) begin
            fails++;
            $display("FAIL R6 both on act=%h exp_overlap=0", act);
        end
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] prev_lv;
        logic [7:0] new_lv;
        logic [7:0] mid_lv;
        string      tag;

        // R9: gates off while held in reset and before the first sample
        #25;
        chk("R9 reset", 8'hF0);
        @(posedge clk);
        #3 rst_n = 1'b1;
        #2 chk("R9 before first sample", 8'hF0);

        prev_lv = '0;
        for (int i = 0; i < 12; i++) begin
            mode   = VEC[i][8:7];
            mute_n = VEC[i][6];
            pwm    = VEC[i][5:4];
            new_lv = ch2lv(VEC[i][3:0]);
            for (int k = 0; k < 4; k++) begin
                if (mode != 2'b00 && prev_lv[2*k +: 2] != new_lv[2*k +: 2])
                    mid_lv[2*k +: 2] = 2'd0;
                else
                    mid_lv[2*k +: 2] = new_lv[2*k +: 2];
            end
            if (!mute_n)                 tag = "R7";
            else if (VEC[i][3:0] == 4'd0) tag = "R8";
            else if (mode[1])             tag = "R5";
            else if (mode == 2'b01)       tag = "R4";
            else                          tag = "R3";
            @(posedge clk);
            #5  chk({tag, " after rising edge"}, enc(mid_lv));
            #10 chk({"R1 R2 ", tag, " after falling edge"}, enc(new_lv));
            prev_lv = new_lv;
        end

        // R9: asynchronous reset, then enter mute straight from reset
        rst_n  = 1'b0;
        mute_n = 1'b0;
        mode   = 2'b00;
        pwm    = 2'b00;
        #1 chk("R9 async reset", 8'hF0);
        @(posedge clk);
        #3 rst_n = 1'b1;
        @(posedge clk);
        #5 chk("R7 muted from boot", 8'hF0);
        // R8: mute released with PWM unchanged, so gates stay off
        mute_n = 1'b1;
        @(posedge clk);
        #5 chk("R8 no PWM edge", 8'hF0);
        // R8: only channel 0 sees an edge, so only channel 0 resumes
        pwm = 2'b01;
        @(posedge clk);
        #5 chk("R8 channel 0 resumes", enc(ch2lv(4'b00_01)));
        #8 rst_n = 1'b0;
        #1 chk("R9 reset while driving", 8'hF0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule